// File: doc/BRIEF.md
# Read-Path Byte Scrambler for a Fixed 32 kB Cartridge ROM

This block sits between a 32 kB cartridge ROM and the CPU data bus. The ROM is mapped at 4000h through BFFFh. A CPU write to any address in that window loads a 3-bit scramble mode from the low data lines. Every later CPU read from the window returns the ROM byte after a transform chosen by that mode. The transform can be a permutation of the low three bits, the same permutation with the low bits inverted, a mask, or a fixed constant. The block does no banking. It is a copy-protection filter: software that has not set the expected mode gets corrupted data.

The mode register is a small state machine with eight named states. They are MODE_CLEAR (0), MODE_ROT_UP (1), MODE_SUB_UP (2), MODE_CONST_A (3), MODE_ROT_DN (4), MODE_LOW_ONLY (5), MODE_SUB_DN (6) and MODE_CONST_B (7). There are two transitions. LOAD happens on a clock edge with a write inside the window: the next state is the written 3-bit value, from any state. HOLD happens on every other edge: the state is kept. Reset enters MODE_CLEAR.

The read path is combinational. The ROM offset is the CPU address minus 4000h. The data output is driven, and marked as driven, only during a read inside the window.

Top module: `rom_read_scrambler`

## Requirements
- R1: After reset the state is MODE_CLEAR, so a read returns the ROM byte unchanged.
- R2: A write (cpu_wr high at a rising clock edge) to any address from 4000h to BFFFh loads cpu_wdata[2:0] as the new mode. The new mode applies to reads from the next cycle on.
- R3: A write to an address below 4000h or above BFFFh leaves the mode unchanged.
- R4: In mode 0 the read byte equals the ROM byte.
- R5: In mode 1, output bits 7:3 equal ROM bits 7:3, output bit 2 equals ROM bit 0, and output bits 1:0 equal ROM bits 2:1.
- R6: In mode 4, output bits 7:3 equal ROM bits 7:3, output bits 2:1 equal ROM bits 1:0, and output bit 0 equals ROM bit 2.
- R7: In modes 2, 5 and 6, a ROM byte whose low three bits are 001, 010 or 100 reads as F8h.
- R8: In mode 2, a ROM byte whose low three bits are 011, 101 or 110 reads as {ROM[7:3], 1, ~ROM[2], ~ROM[1]}.
- R9: In mode 5, a ROM byte whose low three bits are 011, 101 or 110 reads as {00000, ROM[2:0]}.
- R10: In mode 6, a ROM byte whose low three bits are 011, 101 or 110 reads as {ROM[7:3], ~ROM[1], ~ROM[0], 1}.
- R11: In modes 2, 5 and 6, a ROM byte whose low three bits are 000 or 111 reads unchanged.
- R12: In modes 3 and 7 every read returns 07h.
- R13: rd_drive is high only when cpu_rd is high and the address is inside 4000h–BFFFh. While rd_drive is low, rd_data is 00h. rom_addr equals cpu_addr minus 4000h, modulo 8000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 3 | Low three CPU write-data lines |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| rom_addr | output | 15 | Byte offset into the ROM |
| rom_data | input | 8 | Raw byte from the ROM |
| rd_data | output | 8 | Transformed byte for the CPU |
| rd_drive | output | 1 | High while rd_data should drive the bus |

## Verification
Every mode is entered through a write that has its own window address. In each mode, all 256 ROM byte values are read back. The full sweep separates the three groups of low-bit patterns: zero or all-ones, one bit set, and two bits set. It also shows that bits 7:3 are kept, cleared or replaced. Writes just outside both window edges are issued after a mode whose output differs from the constant modes, so an ignored write is visible in the read data. Reads at addresses outside the window and idle cycles check the drive flag and the offset arithmetic at both window boundaries.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [2:0] {
        MODE_CLEAR    = 3'd0,
        MODE_ROT_UP   = 3'd1,
        MODE_SUB_UP   = 3'd2,
        MODE_CONST_A  = 3'd3,
        MODE_ROT_DN   = 3'd4,
        MODE_LOW_ONLY = 3'd5,
        MODE_SUB_DN   = 3'd6,
        MODE_CONST_B  = 3'd7
    } scr_mode_e;
endpackage

// File: rtl/rrs_window_dec.sv
module rrs_window_dec #(
    parameter int              ADDR_W = 16,
    parameter int              ROM_AW = 15,
    parameter logic [ADDR_W-1:0] WIN_LO = 16'h4000,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'hBFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ROM_AW-1:0] rom_off
);
    localparam logic [ROM_AW-1:0] BASE_LO = WIN_LO[ROM_AW-1:0];

    always_comb begin
        hit     = (addr >= WIN_LO) && (addr <= WIN_HI);
        rom_off = addr[ROM_AW-1:0] - BASE_LO;
    end
endmodule

// File: rtl/rrs_mode_fsm.sv
module rrs_mode_fsm
    import rrs_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] wval,
    output scr_mode_e         mode
);
    scr_mode_e state_q;
    scr_mode_e state_d;

    // LOAD / HOLD transitions
    always_comb begin
        if (load) state_d = scr_mode_e'(wval);
        else      state_d = state_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_CLEAR;
        else        state_q <= state_d;
    end

    assign mode = state_q;
endmodule

// File: rtl/rrs_byte_xform.sv
module rrs_byte_xform
    import rrs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  scr_mode_e         mode,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int                HI_W      = DATA_W - 3;
    localparam logic [DATA_W-1:0] FILL_BYTE = {{HI_W{1'b1}}, 3'b000};
    localparam logic [DATA_W-1:0] CONST_BYTE = DATA_W'(7);

    logic [HI_W-1:0] hi;
    logic [2:0]      lo;
    logic            one_hot;
    logic            two_set;

    always_comb begin
        hi      = din[DATA_W-1:3];
        lo      = din[2:0];
        one_hot = (lo == 3'b001) || (lo == 3'b010) || (lo == 3'b100);
        two_set = (lo == 3'b011) || (lo == 3'b101) || (lo == 3'b110);
        dout    = din;
        unique case (mode)
            MODE_CLEAR:    dout = din;
            MODE_ROT_UP:   dout = {hi, lo[0], lo[2:1]};
            MODE_ROT_DN:   dout = {hi, lo[1:0], lo[2]};
            MODE_CONST_A,
            MODE_CONST_B:  dout = CONST_BYTE;
            MODE_SUB_UP: begin
                if (one_hot)      dout = FILL_BYTE;
                else if (two_set) dout = {hi, 1'b1, ~lo[2], ~lo[1]};
            end
            MODE_LOW_ONLY: begin
                if (one_hot)      dout = FILL_BYTE;
                else if (two_set) dout = {{HI_W{1'b0}}, lo};
            end
            MODE_SUB_DN: begin
                if (one_hot)      dout = FILL_BYTE;
                else if (two_set) dout = {hi, ~lo[1], ~lo[0], 1'b1};
            end
        endcase
    end
endmodule

// File: rtl/rom_read_scrambler.sv
module rom_read_scrambler
    import rrs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int ROM_AW = 15,
    parameter int DATA_W = 8,
    parameter int MODE_W = 3,
    parameter logic [ADDR_W-1:0] WIN_LO = 16'h4000,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'hBFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [MODE_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);
    logic        win_hit;
    scr_mode_e   mode_q;
    logic [DATA_W-1:0] xformed;

    rrs_window_dec #(
        .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_dec (
        .addr(cpu_addr), .hit(win_hit), .rom_off(rom_addr)
    );

    rrs_mode_fsm #(.MODE_W(MODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .load(cpu_wr && win_hit),
        .wval(cpu_wdata), .mode(mode_q)
    );

    rrs_byte_xform #(.DATA_W(DATA_W)) u_xf (
        .mode(mode_q), .din(rom_data), .dout(xformed)
    );

    always_comb begin
        rd_drive = cpu_rd && win_hit;
        rd_data  = rd_drive ? xformed : '0;
    end
endmodule

// File: rtl/rom_read_scrambler_chk.sv
module rom_read_scrambler_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [2:0]  cpu_wdata,
    input logic        cpu_wr,
    input logic [7:0]  rom_data,
    input logic [7:0]  rd_data,
    input logic        rd_drive,
    input logic [2:0]  mode_q
);
    logic in_win;
    assign in_win = (cpu_addr >= 16'h4000) && (cpu_addr <= 16'hBFFF);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && in_win) |=> (mode_q == $past(cpu_wdata)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && in_win) |=> $stable(mode_q));

    p_high_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive && (mode_q == 3'd1 || mode_q == 3'd4))
            |-> (rd_data[7:3] == rom_data[7:3]));

    p_const_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive && mode_q[1:0] == 2'b11) |-> (rd_data == 8'h07));

    p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == 8'h00));
endmodule

bind rom_read_scrambler rom_read_scrambler_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .rom_data(rom_data), .rd_data(rd_data),
    .rd_drive(rd_drive), .mode_q(mode_q)
);

// File: tb/rom_read_scrambler_tb.sv
`timescale 1ns/1ps
module rom_read_scrambler_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [2:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [14:0] rom_addr;
    logic [7:0]  rom_data = '0;
    logic [7:0]  rd_data;
    logic        rd_drive;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rom_read_scrambler u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_addr(rom_addr),
        .rom_data(rom_data), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    function automatic int ref_byte(int m, int d);
        int lo = d & 7;
        int r;
        case (m)
            0: r = d;
            1: r = (d & 'hF8) | ((d << 2) & 4) | ((d >> 1) & 3);
            4: r = (d & 'hF8) | ((d >> 2) & 1) | ((d << 1) & 6);
            3, 7: r = 7;
            default: begin
                if (lo == 1 || lo == 2 || lo == 4) r = 'hF8;
                else if (lo == 3 || lo == 5 || lo == 6) begin
                    if (m == 2)      r = (d & 'hF8) | ((d << 2) & 4) | (((d >> 1) & 3) ^ 7);
                    else if (m == 5) r = d & 7;
                    else             r = (d & 'hF8) | ((d >> 2) & 1) | (((d << 1) & 6) ^ 7);
                end else r = d;
            end
        endcase
        return r & 'hFF;
    endfunction

    function automatic string tag_of(int m, int d);
        int lo = d & 7;
        case (m)
            0: return "R4";
            1: return "R5";
            4: return "R6";
            3, 7: return "R12";
            default: begin
                if (lo == 1 || lo == 2 || lo == 4) return "R7";
                if (lo == 0 || lo == 7) return "R11";
                if (m == 2) return "R8";
                if (m == 5) return "R9";
                return "R10";
            end
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [15:0] a, logic [2:0] v);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_read(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = a; rom_data = d; cpu_rd = 1'b1;
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state: pass-through
        do_read(16'h4000, 8'hA5);
        check("R1 reset passthrough", rd_data, 8'hA5);
        check("R1 drive", rd_drive, 1);

        // R13 window edges and offset
        check("R13 offset 4000h", rom_addr, 15'h0000);
        do_read(16'hBFFF, 8'h3C);
        check("R13 offset BFFFh", rom_addr, 15'h7FFF);
        check("R13 drive at BFFFh", rd_drive, 1);
        do_read(16'h8123, 8'h3C);
        check("R13 offset 8123h", rom_addr, 15'h4123);
        do_read(16'h3FFF, 8'h5A);
        check("R13 below drive", rd_drive, 0);
        check("R13 below data", rd_data, 0);
        do_read(16'hC000, 8'h5A);
        check("R13 above drive", rd_drive, 0);
        check("R13 above data", rd_data, 0);
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'h6000; #1;
        check("R13 idle drive", rd_drive, 0);
        check("R13 idle data", rd_data, 0);

        // R2 plus R4..R12: every mode, every byte
        for (int m = 0; m < 8; m++) begin
            do_write(16'h4000 + 16'(m) * 16'h1000 + 16'(m), 3'(m));
            for (int d = 0; d < 256; d++) begin
                do_read(16'h4000 + 16'(d) * 16'h0080, 8'(d));
                check($sformatf("%s R2 mode=%0d d=%0h", tag_of(m, d), m, d),
                      rd_data, ref_byte(m, d));
            end
        end

        // R3 writes outside the window are ignored
        do_write(16'hBFFF, 3'd1);
        do_write(16'h3FFF, 3'd3);
        do_write(16'hC000, 3'd7);
        do_write(16'h0000, 3'd5);
        do_read(16'h5000, 8'h01);
        check("R3 mode kept after outside writes", rd_data, 8'h04);
        do_read(16'h5000, 8'h96);
        check("R3 mode kept d=96h", rd_data, ref_byte(1, 'h96));

        // R2 load at the low edge, effective next cycle
        do_write(16'h4000, 3'd5);
        do_read(16'h4001, 8'hE3);
        check("R2 low-edge load", rd_data, 8'h03);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule